// File: doc/BRIEF.md
# Configurable I/O Pad Register Cell

This block models the storage path of one configurable I/O cell. It has two storage elements: one on the inbound path, which samples the pad, and one on the outbound path, which holds the data that drives the pad. Each element can be set to work as a rising-edge flip-flop or as a level-sensitive latch that is open while the clock is low. A single clock-enable input, active high, is shared by both elements. A static routing field decides which of the two elements obey that enable. An element that is left off the route behaves as if its enable were always high.

A global set/reset input is asynchronous and overrides every other input. It loads each element with its own configured value, either all ones or all zeros. Two inbound taps each pick, independently, either the live pad value or the stored inbound value. The pad drive picks either the stored outbound value or the live outbound data.

All configuration inputs are treated as static between global set/reset pulses. The data width is a parameter, so one instance can stand for a group of pad bits that share the same configuration.

Top module: `iocell_regs`

## Requirements
- R1: With `cfg_in_mode`/`cfg_out_mode` at 0 (flip-flop) and the element's effective enable high, the element loads its data input on a rising clock edge. The new value is visible after that edge.
- R2: With the mode bit at 1 (latch) and the effective enable high, the element output follows its data input while `clk` is low. While `clk` is high, the output keeps the value present at the rising edge.
- R3: When an element's effective enable is low, its stored value does not change, in either mode.
- R4: While `gsr` is high, the inbound element holds all ones if `cfg_in_set` is 1 and all zeros otherwise. The outbound element does the same under `cfg_out_set`. This takes effect at once, without a clock edge.
- R5: `cfg_ce_route` bit 0 makes the inbound element obey `ce`, and bit 1 does the same for the outbound element. An element whose bit is 0 is always enabled, whatever `ce` is. `ce` is active high, with no inversion option.
- R6: `i1` presents the stored inbound value when `cfg_i1_stored` is 1 and `pad_in` when it is 0. `i2` makes the same choice under `cfg_i2_stored`, independently of `i1`.
- R7: `pad_out` presents the stored outbound value when `cfg_out_stored` is 1 and `out_d` when it is 0.
- R8: While `gsr` is high, clock edges, `ce` and data have no effect on either element. After release, normal operation resumes at the first qualifying clock condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; rising edge for flip-flops, low level opens latches |
| gsr | input | 1 | Asynchronous global set/reset, active high |
| ce | input | 1 | Shared clock enable, active high |
| cfg_ce_route | input | 2 | Bit 0: inbound element obeys `ce`; bit 1: outbound element obeys `ce` |
| cfg_in_mode | input | 1 | Inbound element: 0 flip-flop, 1 latch |
| cfg_out_mode | input | 1 | Outbound element: 0 flip-flop, 1 latch |
| cfg_in_set | input | 1 | Inbound init value: 1 all ones, 0 all zeros |
| cfg_out_set | input | 1 | Outbound init value: 1 all ones, 0 all zeros |
| cfg_i1_stored | input | 1 | `i1` source: 1 stored, 0 pad |
| cfg_i2_stored | input | 1 | `i2` source: 1 stored, 0 pad |
| cfg_out_stored | input | 1 | `pad_out` source: 1 stored, 0 `out_d` |
| pad_in | input | WIDTH | Value arriving from the pad |
| out_d | input | WIDTH | Data to be driven onto the pad |
| i1 | output | WIDTH | First inbound tap |
| i2 | output | WIDTH | Second inbound tap |
| pad_out | output | WIDTH | Value driving the pad |

## Verification
Two functions can land in the same cycle: the global set/reset and a normal capture. Both are provoked together. `gsr` is raised in the low phase of the clock while `ce` is high and new data sits at both element inputs, which is exactly when an open latch would pass that data. It is then held across two rising edges, at which enabled flip-flops would otherwise load. Both outputs are judged against the configured init values, both during the pulse and again after the edges. The first step after release is then checked, to confirm that capture resumes normally.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

    typedef enum logic {
        ELEM_FLOP  = 1'b0,
        ELEM_LATCH = 1'b1
    } elem_mode_e;

    // element indices; the routing field bit order follows these
    localparam int IDX_IN   = 0;
    localparam int IDX_OUT  = 1;
    localparam int NUM_ELEM = 2;

    // output selector indices
    localparam int TAP_I1  = 0;
    localparam int TAP_I2  = 1;
    localparam int TAP_PAD = 2;
    localparam int NUM_TAP = 3;

endpackage

// File: rtl/iocell_ce_route.sv
module iocell_ce_route #(
    parameter int NUM_ELEM = 2
) (
    input  logic                ce,
    input  logic [NUM_ELEM-1:0] route,
    output logic [NUM_ELEM-1:0] en
);

    // an element outside the route sees a permanently high enable
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_route
        assign en[g] = route[g] ? ce : 1'b1;
    end

endmodule

// File: rtl/iocell_store.sv
module iocell_store
    import iocell_pkg::*;
#(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             gsr,
    input  logic             en,
    input  elem_mode_e       mode,
    input  logic             init_set,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] flop;
    } store_t;

    logic [WIDTH-1:0] init_val;
    store_t           st_d, st_q;
    logic [WIDTH-1:0] lat_q;

    assign init_val = {WIDTH{init_set}};

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.flop = d;
        end
    end

    always_ff @(posedge clk or posedge gsr) begin
        if (gsr) begin
            st_q <= '{flop: init_val};
        end else begin
            st_q <= st_d;
        end
    end

    // level-sensitive path: open while clk is low and enabled
    always_latch begin
        if (gsr) begin
            lat_q <= init_val;
        end else if (!clk && en) begin
            lat_q <= d;
        end
    end

    assign q = (mode == ELEM_LATCH) ? lat_q : st_q.flop;

endmodule

// File: rtl/iocell_tap.sv
module iocell_tap #(
    parameter int WIDTH = 1
) (
    input  logic             use_stored,
    input  logic [WIDTH-1:0] direct,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);

    assign y = use_stored ? stored : direct;

endmodule

// File: rtl/iocell_regs.sv
module iocell_regs
    import iocell_pkg::*;
#(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             gsr,
    input  logic             ce,
    input  logic [1:0]       cfg_ce_route,
    input  logic             cfg_in_mode,
    input  logic             cfg_out_mode,
    input  logic             cfg_in_set,
    input  logic             cfg_out_set,
    input  logic             cfg_i1_stored,
    input  logic             cfg_i2_stored,
    input  logic             cfg_out_stored,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] out_d,
    output logic [WIDTH-1:0] i1,
    output logic [WIDTH-1:0] i2,
    output logic [WIDTH-1:0] pad_out
);

    logic [NUM_ELEM-1:0]            elem_en;
    logic [NUM_ELEM-1:0]            elem_mode;
    logic [NUM_ELEM-1:0]            elem_set;
    logic [NUM_ELEM-1:0][WIDTH-1:0] elem_d;
    logic [NUM_ELEM-1:0][WIDTH-1:0] elem_q;

    logic [NUM_TAP-1:0]             tap_sel;
    logic [NUM_TAP-1:0][WIDTH-1:0]  tap_dir;
    logic [NUM_TAP-1:0][WIDTH-1:0]  tap_sto;
    logic [NUM_TAP-1:0][WIDTH-1:0]  tap_y;

    logic [WIDTH-1:0]               in_q;
    logic [WIDTH-1:0]               out_q;

    iocell_ce_route #(
        .NUM_ELEM (NUM_ELEM)
    ) u_route (
        .ce    (ce),
        .route (cfg_ce_route),
        .en    (elem_en)
    );

    assign elem_d[IDX_IN]     = pad_in;
    assign elem_d[IDX_OUT]    = out_d;
    assign elem_mode[IDX_IN]  = cfg_in_mode;
    assign elem_mode[IDX_OUT] = cfg_out_mode;
    assign elem_set[IDX_IN]   = cfg_in_set;
    assign elem_set[IDX_OUT]  = cfg_out_set;

    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
        iocell_store #(
            .WIDTH (WIDTH)
        ) u_store (
            .clk      (clk),
            .gsr      (gsr),
            .en       (elem_en[g]),
            .mode     (elem_mode_e'(elem_mode[g])),
            .init_set (elem_set[g]),
            .d        (elem_d[g]),
            .q        (elem_q[g])
        );
    end

    assign in_q  = elem_q[IDX_IN];
    assign out_q = elem_q[IDX_OUT];

    assign tap_sel[TAP_I1]  = cfg_i1_stored;
    assign tap_sel[TAP_I2]  = cfg_i2_stored;
    assign tap_sel[TAP_PAD] = cfg_out_stored;
    assign tap_dir[TAP_I1]  = pad_in;
    assign tap_dir[TAP_I2]  = pad_in;
    assign tap_dir[TAP_PAD] = out_d;
    assign tap_sto[TAP_I1]  = in_q;
    assign tap_sto[TAP_I2]  = in_q;
    assign tap_sto[TAP_PAD] = out_q;

    for (genvar t = 0; t < NUM_TAP; t++) begin : g_tap
        iocell_tap #(
            .WIDTH (WIDTH)
        ) u_tap (
            .use_stored (tap_sel[t]),
            .direct     (tap_dir[t]),
            .stored     (tap_sto[t]),
            .y          (tap_y[t])
        );
    end

    assign i1      = tap_y[TAP_I1];
    assign i2      = tap_y[TAP_I2];
    assign pad_out = tap_y[TAP_PAD];

endmodule

// File: rtl/iocell_regs_chk.sv
module iocell_regs_chk #(
    parameter int WIDTH = 1
) (
    input logic             clk,
    input logic             gsr,
    input logic             ce,
    input logic [1:0]       cfg_ce_route,
    input logic             cfg_in_mode,
    input logic             cfg_out_mode,
    input logic             cfg_in_set,
    input logic             cfg_out_set,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] out_d,
    input logic [WIDTH-1:0] in_q,
    input logic [WIDTH-1:0] out_q
);

    // R1
    in_flop_capture_chk: assert property (@(posedge clk) disable iff (gsr)
        (!cfg_in_mode && (ce || !cfg_ce_route[0])) |=> (in_q == $past(pad_in)));

    // R3
    in_flop_hold_chk: assert property (@(posedge clk) disable iff (gsr)
        (!cfg_in_mode && cfg_ce_route[0] && !ce) |=> $stable(in_q));

    // R3
    out_flop_hold_chk: assert property (@(posedge clk) disable iff (gsr)
        (!cfg_out_mode && cfg_ce_route[1] && !ce) |=> $stable(out_q));

    // R2
    in_latch_open_chk: assert property (@(posedge clk) disable iff (gsr)
        (cfg_in_mode && (ce || !cfg_ce_route[0])) |-> (in_q == pad_in));

    // R4
    gsr_init_chk: assert property (@(posedge clk)
        gsr |-> (in_q == {WIDTH{cfg_in_set}}) && (out_q == {WIDTH{cfg_out_set}}));

    // R5
    out_unrouted_chk: assert property (@(posedge clk) disable iff (gsr)
        (!cfg_out_mode && !cfg_ce_route[1]) |=> (out_q == $past(out_d)));

endmodule

bind iocell_regs iocell_regs_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .gsr          (gsr),
    .ce           (ce),
    .cfg_ce_route (cfg_ce_route),
    .cfg_in_mode  (cfg_in_mode),
    .cfg_out_mode (cfg_out_mode),
    .cfg_in_set   (cfg_in_set),
    .cfg_out_set  (cfg_out_set),
    .pad_in       (pad_in),
    .out_d        (out_d),
    .in_q         (in_q),
    .out_q        (out_q)
);

// File: tb/tb_iocell_regs.sv
`timescale 1ns/1ps
module tb_iocell_regs;

    localparam int W = 4;

    // {ce, pad_in, out_d}
    localparam logic [8:0] VEC [16] = '{
        {1'b1, 4'hA, 4'h5}, {1'b1, 4'h3, 4'hC}, {1'b0, 4'hF, 4'h0},
        {1'b0, 4'h1, 4'h8}, {1'b1, 4'h6, 4'h9}, {1'b1, 4'h6, 4'h9},
        {1'b0, 4'h0, 4'hF}, {1'b1, 4'hE, 4'h1}, {1'b0, 4'h7, 4'h7},
        {1'b1, 4'h2, 4'hD}, {1'b1, 4'hB, 4'h4}, {1'b0, 4'h4, 4'hB},
        {1'b1, 4'h9, 4'h2}, {1'b0, 4'hD, 4'h6}, {1'b1, 4'h5, 4'hA},
        {1'b1, 4'h0, 4'h0}
    };

    logic         clk = 1'b0;
    logic         gsr = 1'b0;
    logic         ce = 1'b0;
    logic [1:0]   c_route = 2'b11;
    logic         c_in_mode = 1'b0, c_out_mode = 1'b0;
    logic         c_in_set = 1'b0, c_out_set = 1'b1;
    logic         c_i1s = 1'b1, c_i2s = 1'b0, c_os = 1'b1;
    logic [W-1:0] pad_in = '0, out_d = '0;
    logic [W-1:0] i1, i2, pad_out;

    logic [W-1:0] ref_in_ff, ref_in_lat, ref_out_ff, ref_out_lat;
    int  total = 0;
    int  bad = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    iocell_regs #(.WIDTH(W)) dut (
        .clk            (clk),
        .gsr            (gsr),
        .ce             (ce),
        .cfg_ce_route   (c_route),
        .cfg_in_mode    (c_in_mode),
        .cfg_out_mode   (c_out_mode),
        .cfg_in_set     (c_in_set),
        .cfg_out_set    (c_out_set),
        .cfg_i1_stored  (c_i1s),
        .cfg_i2_stored  (c_i2s),
        .cfg_out_stored (c_os),
        .pad_in         (pad_in),
        .out_d          (out_d),
        .i1             (i1),
        .i2             (i2),
        .pad_out        (pad_out)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic ref_init();
        ref_in_ff   = {W{c_in_set}};
        ref_in_lat  = {W{c_in_set}};
        ref_out_ff  = {W{c_out_set}};
        ref_out_lat = {W{c_out_set}};
    endtask

    // returns at posedge+1 with gsr just released
    task automatic apply_cfg(input logic [1:0] rt, input logic im, input logic om,
                             input logic is, input logic os_set, input logic s1,
                             input logic s2, input logic so);
        @(posedge clk); #1;
        c_route = rt; c_in_mode = im; c_out_mode = om;
        c_in_set = is; c_out_set = os_set;
        c_i1s = s1; c_i2s = s2; c_os = so;
        #1 gsr = 1'b1;
        @(posedge clk);
        @(posedge clk); #1;
        gsr = 1'b0;
        ref_init();
    endtask

    // called at posedge+1; samples in the following low phase
    task automatic step(input string tag, input bit mid, input logic c,
                        input logic [W-1:0] pi, input logic [W-1:0] od);
        logic ie, oe;
        logic [W-1:0] iq, oq, pre;
        string ti, to;
        ce = c; pad_in = pi; out_d = od;
        ti = (tag == "") ? "R6" : tag;
        to = (tag == "") ? "R7" : tag;
        ie = c_route[0] ? c : 1'b1;
        oe = c_route[1] ? c : 1'b1;
        pre = c_in_mode ? ref_in_lat : ref_in_ff;
        if (mid) begin
            #2;
            // R2: clock high, latch keeps the value from the last rising edge
            chk("R2", i1, c_i1s ? pre : pi);
            #4;
        end else begin
            #6;
        end
        if (ie) ref_in_lat = pi;
        if (oe) ref_out_lat = od;
        iq = c_in_mode ? ref_in_lat : ref_in_ff;
        oq = c_out_mode ? ref_out_lat : ref_out_ff;
        chk(ti, i1, c_i1s ? iq : pi);
        chk(ti, i2, c_i2s ? iq : pi);
        chk(to, pad_out, c_os ? oq : od);
        if (ie) ref_in_ff = pi;
        if (oe) ref_out_ff = od;
        @(posedge clk); #1;
    endtask

    initial begin
        #1 gsr = 1'b1;

        // R4: reset state, inbound clears, outbound sets
        apply_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R4", i1, 4'h0);
        chk("R4", pad_out, 4'hF);

        // table across eight configurations (R6, R7, plus R1 R2 R3 R5)
        for (int c = 0; c < 8; c++) begin
            apply_cfg(2'(c), 1'(c >> 2), ~1'(c), 1'(c), 1'(c >> 1),
                      1'b1, 1'(c >> 2), (c != 7));
            for (int v = 0; v < 16; v++) begin
                step("", 1'b0, VEC[v][8], VEC[v][7:4], VEC[v][3:0]);
            end
        end

        // R1: flip-flop capture on the rising edge
        apply_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        step("R1", 1'b1, 1'b1, 4'h5, 4'h6);
        step("R1", 1'b0, 1'b1, 4'h9, 4'h3);
        // R3: disabled flip-flop holds
        step("R3", 1'b0, 1'b0, 4'h7, 4'h7);
        step("R3", 1'b0, 1'b0, 4'h1, 4'h2);

        // R2: latch open while low, closed while high
        apply_cfg(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        step("R2", 1'b0, 1'b1, 4'h3, 4'h3);
        step("R2", 1'b1, 1'b1, 4'hC, 4'h4);
        // R3: disabled latch holds
        step("R3", 1'b0, 1'b0, 4'h8, 4'h8);

        // R5: route to inbound only, outbound always enabled
        apply_cfg(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        step("R5", 1'b0, 1'b0, 4'h2, 4'h2);
        step("R5", 1'b0, 1'b0, 4'h6, 4'hB);
        // R5: route to outbound only, inbound always enabled
        apply_cfg(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        step("R5", 1'b0, 1'b0, 4'hA, 4'h3);
        step("R5", 1'b0, 1'b0, 4'h4, 4'h5);

        // R4 and R8: set/reset meets enabled capture, both modes
        for (int m = 0; m < 2; m++) begin
            apply_cfg(2'b11, 1'(m), 1'(m), 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
            step("R8", 1'b0, 1'b1, 4'h5, 4'h5);
            #4;
            gsr = 1'b1; ce = 1'b1; pad_in = 4'h2; out_d = 4'hE;
            #1;
            chk("R4", i1, 4'hF);
            chk("R4", pad_out, 4'h0);
            @(posedge clk);
            @(posedge clk); #5;
            chk("R8", i1, 4'hF);
            chk("R8", pad_out, 4'h0);
            @(posedge clk); #1;
            gsr = 1'b0;
            ref_init();
            step("R8", 1'b0, 1'b1, 4'h6, 4'h9);
            step("R8", 1'b0, 1'b1, 4'h1, 4'h7);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule